// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one burst request into the column addresses that a double-data-rate memory array visits during a read or write burst. A request gives a starting column, a burst-length code and an order select. Because the pins move two data words per clock, the generator emits one pair of column addresses per clock cycle. The pair is an even-beat address and an odd-beat address.

The burst stays inside an aligned block of columns whose size equals the burst length. The column bits above that block never change during a burst. The low bits advance either by counting up modulo the burst length or by XOR with the beat number. When the count reaches the edge of the block it wraps back to the start of the same block. A flag marks the final pair of the burst. A reserved length code is refused and raises an error flag. A new request may be taken in the final cycle of a burst, so bursts can follow each other with no idle cycle.

Top module: `burst_col_gen`

## Requirements
- R1: `burstCode` selects the burst length: 3'd1 gives 2 beats, 3'd2 gives 4 beats and 3'd3 gives 8 beats. Codes 0 and 4 to 7 are reserved.
- R2: A start taken at a clock edge makes `outValid` high from the next cycle for exactly length/2 consecutive cycles. In pair cycle j, `addrEven` carries beat 2j and `addrOdd` carries beat 2j+1.
- R3: When `interleave` is 0, the low log2(length) bits of beat k are (s + k) mod length, where s is the same low field of `startCol`.
- R4: When `interleave` is 1, the low log2(length) bits of beat k are s XOR k.
- R5: The address bits above the low log2(length) bits equal those of `startCol` on every beat, so the burst wraps inside its aligned block.
- R6: `lastBeat` is high in the final pair cycle of a burst and low at every other time.
- R7: A start with a reserved code starts no burst. Instead `modeErr` is high for exactly the one cycle after that edge.
- R8: During a burst, a start that comes before the final pair cycle is ignored. Changes on `startCol`, `burstCode` and `interleave` in that time do not alter the running burst.
- R9: A start in the final pair cycle is taken, and its first pair follows in the very next cycle.
- R10: While reset is held and just after it, `outValid`, `lastBeat` and `modeErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to begin a burst, sampled on each edge |
| startCol | input | COL_W | Starting column of the burst |
| burstCode | input | 3 | Burst-length code (see R1) |
| interleave | input | 1 | 0 selects counting order, 1 selects XOR order |
| outValid | output | 1 | An address pair is presented |
| addrEven | output | COL_W | Column for even beat 2j |
| addrOdd | output | COL_W | Column for odd beat 2j+1 |
| lastBeat | output | 1 | Final pair of the burst |
| modeErr | output | 1 | A reserved length code was refused |

## Verification
The bench builds the block with COL_W = 6. This makes the column space small enough to sweep every start column with each of the three lengths and both orders. Every wrap point and every block position inside a 64-column space is therefore checked against a model of the beat formulas. The narrow width still leaves three column bits above the largest block, which lets the bench confirm that the upper bits stay fixed. Directed cases then cover the reserved codes, a start and mode changes during a running burst, and a back-to-back start in the final cycle.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  // Largest burst is 8 beats, so the wrapping field is 3 bits wide
  localparam int MAX_LOG = 3;
  localparam int PAIR_W  = MAX_LOG - 1;

  typedef struct packed {
    logic load;   // capture a new burst request
    logic step;   // move to the next pair of beats
  } strobe_t;

  // log2 of the burst length; 0 marks a reserved code
  function automatic logic [1:0] lenLog(input logic [2:0] code);
    case (code)
      3'd1:    lenLog = 2'd1;
      3'd2:    lenLog = 2'd2;
      3'd3:    lenLog = 2'd3;
      default: lenLog = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_addr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startReq,
  input  logic [2:0] burstCode,
  output strobe_t    strb,
  output logic       outValid,
  output logic       lastBeat,
  output logic       modeErr
);

  logic              busy;
  logic [PAIR_W-1:0] remPairs;
  logic [PAIR_W-1:0] pairsM1;
  logic [1:0]        codeLog;
  logic              lastPair;
  logic              free;
  logic              accept;
  logic              reject;
  logic              errReg;

  assign codeLog  = lenLog(burstCode);
  assign lastPair = busy && (remPairs == '0);
  assign free     = !busy || lastPair;
  assign accept   = startReq && free && (codeLog != 2'd0);
  assign reject   = startReq && free && (codeLog == 2'd0);

  always_comb begin
    case (codeLog)
      2'd2:    pairsM1 = PAIR_W'(1);
      2'd3:    pairsM1 = PAIR_W'(3);
      default: pairsM1 = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      remPairs <= '0;
      errReg   <= 1'b0;
    end else begin
      errReg <= reject;
      if (accept) begin
        busy     <= 1'b1;
        remPairs <= pairsM1;
      end else if (busy) begin
        if (remPairs == '0) busy <= 1'b0;
        else                remPairs <= remPairs - 1'b1;
      end
    end
  end

  assign strb.load = accept;
  assign strb.step = busy && (remPairs != '0);

  assign outValid = busy;
  assign lastBeat = lastPair;
  assign modeErr  = errReg;

  // R6: the final flag only appears together with a presented pair
  assert_last_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lastBeat |-> outValid);

  // R7: a refused request never yields a pair in the flagged cycle
  assert_err_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    modeErr |-> !outValid);

  // R2: with no new request, the burst ends right after its final pair
  assert_burst_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lastBeat && !startReq) |=> !outValid);

endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_addr_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strb,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       burstCode,
  input  logic             interleave,
  output logic [COL_W-1:0] addrEven,
  output logic [COL_W-1:0] addrOdd
);

  localparam int UP_W = COL_W - MAX_LOG;

  logic [COL_W-1:0]   baseCol;
  logic [MAX_LOG-1:0] startLow;
  logic [MAX_LOG-1:0] lenMask;
  logic               ilv;
  logic [MAX_LOG-1:0] beatIdx;
  logic [MAX_LOG-1:0] newMask;
  logic [MAX_LOG-1:0] lowEven;
  logic [MAX_LOG-1:0] lowOdd;

  assign newMask = MAX_LOG'((4'd1 << lenLog(burstCode)) - 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseCol  <= '0;
      startLow <= '0;
      lenMask  <= '0;
      ilv      <= 1'b0;
      beatIdx  <= '0;
    end else if (strb.load) begin
      baseCol  <= startCol & ~{{UP_W{1'b0}}, newMask};
      startLow <= startCol[MAX_LOG-1:0] & newMask;
      lenMask  <= newMask;
      ilv      <= interleave;
      beatIdx  <= '0;
    end else if (strb.step) begin
      beatIdx  <= beatIdx + MAX_LOG'(2);
    end
  end

  function automatic logic [MAX_LOG-1:0] lowOf(input logic [MAX_LOG-1:0] k);
    if (ilv) lowOf = (startLow ^ k) & lenMask;
    else     lowOf = (startLow + k) & lenMask;
  endfunction

  assign lowEven  = lowOf(beatIdx);
  assign lowOdd   = lowOf(beatIdx | MAX_LOG'(1));
  assign addrEven = baseCol | {{UP_W{1'b0}}, lowEven};
  assign addrOdd  = baseCol | {{UP_W{1'b0}}, lowOdd};

  // R5: bits above the largest block follow the requested column
  assert_upper_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> addrEven[COL_W-1:MAX_LOG] == $past(startCol[COL_W-1:MAX_LOG]));

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_addr_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startReq,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       burstCode,
  input  logic             interleave,
  output logic             outValid,
  output logic [COL_W-1:0] addrEven,
  output logic [COL_W-1:0] addrOdd,
  output logic             lastBeat,
  output logic             modeErr
);

  strobe_t strb;

  burst_col_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .startReq  (startReq),
    .burstCode (burstCode),
    .strb      (strb),
    .outValid  (outValid),
    .lastBeat  (lastBeat),
    .modeErr   (modeErr)
  );

  burst_col_dp #(.COL_W(COL_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .startCol   (startCol),
    .burstCode  (burstCode),
    .interleave (interleave),
    .addrEven   (addrEven),
    .addrOdd    (addrOdd)
  );

  // R2: the two beats of a pair always name distinct columns
  assert_pair_distinct_R2: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> addrEven != addrOdd);

  // R5: inside one burst the bits above the largest block never move
  assert_block_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && $past(outValid) && !$past(lastBeat))
      |-> $stable(addrEven[COL_W-1:MAX_LOG]));

endmodule

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;

  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          startReq = 1'b0;
  logic [CW-1:0] startCol = '0;
  logic [2:0]    burstCode = 3'd0;
  logic          interleave = 1'b0;
  logic          outValid, lastBeat, modeErr;
  logic [CW-1:0] addrEven, addrOdd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_col_gen #(.COL_W(CW)) u_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .startCol(startCol),
    .burstCode(burstCode), .interleave(interleave), .outValid(outValid),
    .addrEven(addrEven), .addrOdd(addrOdd), .lastBeat(lastBeat), .modeErr(modeErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected column of beat k from the R3/R4/R5 formulas
  function automatic int expAddr(input int col, input int lg, input bit ilv, input int k);
    int bl = 1 << lg;
    int s  = col % bl;
    int lo = ilv ? (s ^ k) : ((s + k) % bl);
    return (col - s) + lo;
  endfunction

  // Called just after a negedge in pair cycle j
  task automatic checkPair(input int col, input int lg, input bit ilv, input int j);
    int npairs = (1 << lg) / 2;
    check(outValid == 1'b1, "R2 valid", int'(outValid), 1);
    check(int'(addrEven) == expAddr(col, lg, ilv, 2*j),
          ilv ? "R4 even beat" : "R3 even beat", int'(addrEven), expAddr(col, lg, ilv, 2*j));
    check(int'(addrOdd) == expAddr(col, lg, ilv, 2*j+1),
          ilv ? "R4 odd beat" : "R3 odd beat", int'(addrOdd), expAddr(col, lg, ilv, 2*j+1));
    check((int'(addrEven) / (1 << lg)) == (col / (1 << lg)), "R5 block bits",
          int'(addrEven) / (1 << lg), col / (1 << lg));
    check(lastBeat == (j == npairs - 1), "R6 last flag", int'(lastBeat), int'(j == npairs - 1));
  endtask

  task automatic testReset();
    check(!outValid && !lastBeat && !modeErr, "R10 reset outputs",
          int'({outValid, lastBeat, modeErr}), 0);
  endtask

  // R1..R6: one full burst with an idle cycle after it
  task automatic runBurst(input int col, input int code, input bit ilv);
    int lg = code;
    @(negedge clk);
    startReq = 1; startCol = CW'(col); burstCode = 3'(code); interleave = ilv;
    for (int j = 0; j < (1 << lg) / 2; j++) begin
      @(negedge clk);
      startReq = 0;
      checkPair(col, lg, ilv, j);
    end
    @(negedge clk);
    check(!outValid && !lastBeat, "R2 burst length (R1 code)", int'(outValid), 0);
  endtask

  task automatic testSweep();
    for (int code = 1; code <= 3; code++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int col = 0; col < (1 << CW); col++)
          runBurst(col, code, ilv[0]);
  endtask

  // R7: every reserved code raises the error for one cycle only
  task automatic testReserved();
    int codes[5] = '{0, 4, 5, 6, 7};
    foreach (codes[i]) begin
      @(negedge clk);
      startReq = 1; startCol = CW'(13); burstCode = 3'(codes[i]); interleave = 0;
      @(negedge clk);
      startReq = 0;
      check(modeErr && !outValid, "R7 reserved flag", int'({modeErr, outValid}), 2);
      @(negedge clk);
      check(!modeErr && !outValid, "R7 flag one cycle", int'({modeErr, outValid}), 0);
    end
  endtask

  // R8: a start and new mode inputs mid-burst leave the burst untouched
  task automatic testBusyIgnore();
    @(negedge clk);
    startReq = 1; startCol = CW'(45); burstCode = 3'd3; interleave = 0;
    @(negedge clk);
    checkPair(45, 3, 0, 0);
    startCol = CW'(17); burstCode = 3'd1; interleave = 1;
    @(negedge clk);
    checkPair(45, 3, 0, 1);
    @(negedge clk);
    startReq = 0;
    checkPair(45, 3, 0, 2);
    @(negedge clk);
    checkPair(45, 3, 0, 3);
    @(negedge clk);
    check(!outValid, "R8 ignored start", int'(outValid), 0);
  endtask

  // R9: a start in the last pair cycle chains with no gap
  task automatic testBackToBack();
    @(negedge clk);
    startReq = 1; startCol = CW'(6); burstCode = 3'd2; interleave = 0;
    @(negedge clk);
    startReq = 0;
    checkPair(6, 2, 0, 0);
    @(negedge clk);
    checkPair(6, 2, 0, 1);
    startReq = 1; startCol = CW'(58); burstCode = 3'd3; interleave = 1;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      startReq = 0;
      check(outValid, "R9 gapless", int'(outValid), 1);
      checkPair(58, 3, 1, j);
    end
    @(negedge clk);
    check(!outValid, "R9 chain end", int'(outValid), 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1;
    @(negedge clk);
    testReset();
    testSweep();
    testReserved();
    testBusyIgnore();
    testBackToBack();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

endmodule